// File: doc/BRIEF.md
# Forced-Instruction Boot Feeder

This block sits on the data side of an 8-bit CPU bus while the system comes out of reset. While it is in forced mode it supplies every read on the bus itself. The CPU runs a fixed script: one load of the destination pointer, then a long run of single-step block-copy instructions, then a port write that ends the boot phase. The feeder answers each instruction fetch and each operand read with the next script byte. It answers each copy-data read with the next byte of a boot image, which an external image store supplies at an index the feeder drives. Memory writes go through to RAM untouched, so the copied bytes land wherever the CPU's destination pointer says.

The feeder never looks at the address bus. All of its sequencing comes from the cycle type (M1, MREQ, RD, WR, IORQ) and from two internal counters. One is a script position pointer and the other is an image byte counter. This is why the copy is unrolled into one single-step copy per byte: a repeating copy instruction re-fetches from an unchanged program counter, and a feeder that only counts cycles cannot follow that. While forced mode is active, RAM read data is held off the bus. The first I/O write after the script has been fully fetched ends forced mode and hands reads back to RAM.

Top module: `boot_feeder`

## Requirements
- R1: A memory read with M1, MREQ and RD all low is an instruction fetch. In forced mode the block answers it on `feed_data` with `feed_oe` high, using the script byte at the current script position.
- R2: The script is, in order: 11h, DEST low, DEST high; then IMG_BYTES copies of the pair EDh A0h; then 3Eh, CFG, D3h, PORT. Every position past the end reads 00h.
- R3: Operand reads (M1 high, not following a copy opcode) get the operand byte at the script position. These are the destination bytes, the CFG byte and the port byte.
- R4: A read with M1 high that follows the A0h byte of a copy pair is a data read. It is answered with `img_data`, and `img_index` shows the image byte number at that time.
- R5: Each counter moves by exactly one per completed read cycle, at the end of the cycle. This holds however many clocks RD stays low.
- R6: In forced mode `ram_rd_en` is low. `feed_oe` is high only during a memory read in forced mode.
- R7: Memory writes reach RAM in every mode (`ram_wr_en` is high while MREQ and WR are low). They do not move either counter.
- R8: An I/O write (IORQ and WR low) ends forced mode only once the script position has reached the script end. An earlier I/O write has no effect.
- R9: Reset (synchronous, active low) clears both counters and re-enters forced mode.
- R10: `img_index` steps by one per data read, from 0 through IMG_BYTES-1, and the image count never exceeds IMG_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| m1_n | input | 1 | Instruction-fetch marker, active low |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| img_data | input | 8 | Boot image byte at `img_index` |
| img_index | output | 8 | Current boot image byte number |
| feed_data | output | 8 | Byte the feeder puts on the CPU data bus |
| feed_oe | output | 1 | Feeder drives the CPU data bus |
| ram_rd_en | output | 1 | RAM may drive read data onto the bus |
| ram_wr_en | output | 1 | Memory write passes to RAM |
| forced_mode | output | 1 | Forced boot phase active |

## Verification
The hardest situation to reach is the exit. Forced mode ends only when an I/O write arrives with the script pointer at the very end. Getting there takes the whole unrolled copy: several hundred fetches, data reads and writes in the exact order the CPU would issue them. The bench replays that full sequence cycle by cycle and stretches some reads and writes along the way. It issues a premature I/O write in the middle of the copy, which must be ignored. Only after the final port operand does it send the real I/O write.

// File: rtl/boot_feed_pkg.sv
// Shared constants and types for the forced-instruction boot feeder.
// Assumes an 8-bit data bus and the opcode encodings listed below.
package boot_feed_pkg;
    localparam logic [7:0] OPC_LD_DE   = 8'h11;
    localparam logic [7:0] OPC_PREFIX  = 8'hED;
    localparam logic [7:0] OPC_COPY1   = 8'hA0;
    localparam logic [7:0] OPC_LD_A    = 8'h3E;
    localparam logic [7:0] OPC_OUT     = 8'hD3;
    localparam logic [7:0] OPC_NOP     = 8'h00;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_SCRIPT = 2'd1,
        SRC_IMAGE  = 2'd2
    } feed_src_e;
endpackage

// File: rtl/bus_cycle_decode.sv
// Classifies CPU bus cycles from the active-low strobes and marks the end
// of each memory read. Assumes the strobes are synchronous to clk.
module bus_cycle_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic m1_n,
    input  logic mreq_n,
    input  logic iorq_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic mem_rd,
    output logic mem_wr,
    output logic io_wr,
    output logic rd_end,
    output logic cyc_m1
);
    logic rd_q;
    logic m1_q;

    // Combinational cycle classification from the live strobes.
    always_comb begin
        mem_rd = !mreq_n && !rd_n;
        mem_wr = !mreq_n && !wr_n;
        io_wr  = !iorq_n && !wr_n;
    end

    // Remember whether a read was active and whether M1 was seen during it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            m1_q <= 1'b0;
        end else begin
            rd_q <= mem_rd;
            if (mem_rd) m1_q <= m1_q || !m1_n;
            else        m1_q <= 1'b0;
        end
    end

    // End of read cycle, and the M1 flag that holds until that end.
    always_comb begin
        rd_end = rd_q && !mem_rd;
        cyc_m1 = m1_q || (!m1_n && mem_rd);
    end
endmodule

// File: rtl/boot_script_rom.sv
// Computes the forced instruction script byte for a script position:
// a destination load, IMG_BYTES copy pairs, an accumulator load and the
// exit port write. Positions past the end return a no-op byte.
module boot_script_rom
    import boot_feed_pkg::*;
#(
    parameter int          IMG_BYTES = 256,
    parameter logic [15:0] DEST      = 16'h4000,
    parameter logic [7:0]  CFG       = 8'h01,
    parameter logic [7:0]  PORT      = 8'hF8,
    parameter int          SP_W      = 10
) (
    input  logic [SP_W-1:0] sp,
    output logic [7:0]      script_byte,
    output logic            copy_tail
);
    localparam int BODY_END = 3 + 2 * IMG_BYTES;

    logic [SP_W-1:0] rel_body;
    logic [SP_W-1:0] rel_tail;

    // Offsets of the position inside the copy body and inside the trailer.
    always_comb begin
        rel_body = sp - SP_W'(3);
        rel_tail = sp - SP_W'(BODY_END);
    end

    // Select the script byte and flag the second byte of a copy pair.
    always_comb begin
        script_byte = OPC_NOP;
        copy_tail   = 1'b0;
        if (sp == SP_W'(0)) begin
            script_byte = OPC_LD_DE;
        end else if (sp == SP_W'(1)) begin
            script_byte = DEST[7:0];
        end else if (sp == SP_W'(2)) begin
            script_byte = DEST[15:8];
        end else if (sp < SP_W'(BODY_END)) begin
            if (rel_body[0]) begin
                script_byte = OPC_COPY1;
                copy_tail   = 1'b1;
            end else begin
                script_byte = OPC_PREFIX;
            end
        end else begin
            case (rel_tail)
                SP_W'(0): script_byte = OPC_LD_A;
                SP_W'(1): script_byte = CFG;
                SP_W'(2): script_byte = OPC_OUT;
                SP_W'(3): script_byte = PORT;
                default:  script_byte = OPC_NOP;
            endcase
        end
    end
endmodule

// File: rtl/feed_sequencer.sv
// Holds the script pointer, the image byte counter, the pending-data flag
// and the forced-mode flag. Every step happens at the end of a read cycle.
// Assumes at most one read is in flight at a time.
module feed_sequencer
    import boot_feed_pkg::*;
#(
    parameter int IMG_BYTES = 256,
    parameter int SP_W      = 10,
    parameter int DC_W      = 9,
    parameter int IDX_W     = 8,
    parameter int SCRIPT_LEN = 519
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_rd,
    input  logic             rd_end,
    input  logic             io_wr,
    input  logic             cyc_m1,
    input  logic             copy_tail,
    output logic [SP_W-1:0]  sp,
    output logic [IDX_W-1:0] img_index,
    output logic             forced,
    output feed_src_e        src
);
    logic [DC_W-1:0] dc;
    logic            pend;
    logic            is_data;

    // A read is a data read when a copy opcode is pending and M1 is absent.
    always_comb begin
        is_data = pend && !cyc_m1;
        if (!forced || !mem_rd) src = SRC_NONE;
        else if (is_data)       src = SRC_IMAGE;
        else                    src = SRC_SCRIPT;
        img_index = dc[IDX_W-1:0];
    end

    // Advance counters at read-cycle end; leave forced mode on the exit write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp     <= '0;
            dc     <= '0;
            pend   <= 1'b0;
            forced <= 1'b1;
        end else if (forced) begin
            if (rd_end) begin
                if (is_data) begin
                    if (dc < DC_W'(IMG_BYTES)) dc <= dc + DC_W'(1);
                    pend <= 1'b0;
                end else begin
                    if (sp < SP_W'(SCRIPT_LEN)) sp <= sp + SP_W'(1);
                    if (copy_tail) pend <= 1'b1;
                end
            end
            if (io_wr && sp == SP_W'(SCRIPT_LEN)) forced <= 1'b0;
        end
    end

    // R5: the script pointer moves only right after a read cycle ended.
    assert_sp_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && sp != $past(sp)) |-> ($past(rd_end) && sp == $past(sp) + SP_W'(1)));

    // R10: the image counter steps by one, only after a read ended.
    assert_img_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dc != $past(dc)) |-> ($past(rd_end) && dc == $past(dc) + DC_W'(1)));

    // R10: never more image bytes than the image holds.
    assert_img_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dc <= DC_W'(IMG_BYTES));

    // R8: forced mode ends only on an I/O write at the script end.
    assert_exit_on_io_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(forced)) |-> ($past(io_wr) && $past(sp) == SP_W'(SCRIPT_LEN)));

    // R9: forced mode is only entered through reset.
    assert_no_reentry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !$rose(forced));
endmodule

// File: rtl/boot_feeder.sv
// Top of the forced-instruction boot feeder. Drives the CPU data bus from a
// fixed script or from the boot image, keeps RAM off reads while forced and
// passes memory writes to RAM. It has no address inputs by design.
module boot_feeder
    import boot_feed_pkg::*;
#(
    parameter int          IMG_BYTES = 256,
    parameter logic [15:0] DEST      = 16'h4000,
    parameter logic [7:0]  CFG       = 8'h01,
    parameter logic [7:0]  PORT      = 8'hF8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       m1_n,
    input  logic       mreq_n,
    input  logic       iorq_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [7:0] img_data,
    output logic [7:0] img_index,
    output logic [7:0] feed_data,
    output logic       feed_oe,
    output logic       ram_rd_en,
    output logic       ram_wr_en,
    output logic       forced_mode
);
    localparam int SCRIPT_LEN = 3 + 2 * IMG_BYTES + 4;
    localparam int SP_W       = $clog2(SCRIPT_LEN + 1);
    localparam int DC_W       = $clog2(IMG_BYTES + 1);
    localparam int IDX_W      = 8;

    logic            mem_rd, mem_wr, io_wr, rd_end, cyc_m1;
    logic [SP_W-1:0] sp;
    logic [7:0]      script_byte;
    logic            copy_tail;
    logic            forced;
    feed_src_e       src;

    bus_cycle_decode u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .m1_n   (m1_n),
        .mreq_n (mreq_n),
        .iorq_n (iorq_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .mem_rd (mem_rd),
        .mem_wr (mem_wr),
        .io_wr  (io_wr),
        .rd_end (rd_end),
        .cyc_m1 (cyc_m1)
    );

    boot_script_rom #(
        .IMG_BYTES (IMG_BYTES),
        .DEST      (DEST),
        .CFG       (CFG),
        .PORT      (PORT),
        .SP_W      (SP_W)
    ) u_script (
        .sp          (sp),
        .script_byte (script_byte),
        .copy_tail   (copy_tail)
    );

    feed_sequencer #(
        .IMG_BYTES  (IMG_BYTES),
        .SP_W       (SP_W),
        .DC_W       (DC_W),
        .IDX_W      (IDX_W),
        .SCRIPT_LEN (SCRIPT_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rd    (mem_rd),
        .rd_end    (rd_end),
        .io_wr     (io_wr),
        .cyc_m1    (cyc_m1),
        .copy_tail (copy_tail),
        .sp        (sp),
        .img_index (img_index),
        .forced    (forced),
        .src       (src)
    );

    // Bus data mux and RAM read/write gating.
    always_comb begin
        feed_oe     = (src != SRC_NONE);
        feed_data   = (src == SRC_IMAGE) ? img_data : script_byte;
        ram_rd_en   = !forced;
        ram_wr_en   = mem_wr;
        forced_mode = forced;
    end

    // R6: the feeder and RAM never both own the read data.
    assert_bus_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        feed_oe |-> !ram_rd_en);

    // R6: the feeder drives only during memory reads.
    assert_drive_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        feed_oe |-> (!mreq_n && !rd_n));
endmodule

// File: tb/tb_boot_feeder.sv
module tb_boot_feeder;
    localparam int          N    = 256;
    localparam logic [15:0] DEST = 16'h4000;
    localparam logic [7:0]  CFG  = 8'h01;
    localparam logic [7:0]  PORT = 8'hF8;
    localparam logic [1:0]  K_OP = 2'd0, K_OPR = 2'd1, K_DAT = 2'd2, K_WR = 2'd3;
    localparam int NVEC = 11;
    // kind[9:8], expected byte[7:0]: the first two copy steps
    localparam logic [9:0] VEC [NVEC] = '{
        {K_OP, 8'h11}, {K_OPR, 8'h00}, {K_OPR, 8'h40},
        {K_OP, 8'hED}, {K_OP, 8'hA0}, {K_DAT, 8'h03}, {K_WR, 8'h00},
        {K_OP, 8'hED}, {K_OP, 8'hA0}, {K_DAT, 8'h0A}, {K_WR, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m1_n = 1'b1, mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] img_data, img_index, feed_data;
    logic feed_oe, ram_rd_en, ram_wr_en, forced_mode;
    int n_chk = 0;
    int n_fail = 0;
    int dcount = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] img_of(input int i);
        return 8'(i * 7 + 3);
    endfunction

    assign img_data = img_of(int'(img_index));

    boot_feeder #(.IMG_BYTES(N), .DEST(DEST), .CFG(CFG), .PORT(PORT)) dut (
        .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
        .rd_n(rd_n), .wr_n(wr_n), .img_data(img_data), .img_index(img_index),
        .feed_data(feed_data), .feed_oe(feed_oe), .ram_rd_en(ram_rd_en),
        .ram_wr_en(ram_wr_en), .forced_mode(forced_mode)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic m1, input logic [7:0] exp, input int hold,
                            input string tag);
        @(negedge clk);
        m1_n = !m1; mreq_n = 1'b0; rd_n = 1'b0;
        repeat (hold) @(negedge clk);
        chk(feed_oe == 1'b1, {tag, " oe"}, int'(feed_oe), 1);
        chk(feed_data == exp, tag, int'(feed_data), int'(exp));
        chk(ram_rd_en == 1'b0, "R6 ram read blocked", int'(ram_rd_en), 0);
        m1_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic data_read(input int hold);
        @(negedge clk);
        mreq_n = 1'b0; rd_n = 1'b0;
        repeat (hold) @(negedge clk);
        chk(img_index == 8'(dcount), "R10 image index", int'(img_index), dcount);
        chk(feed_oe && feed_data == img_of(dcount), "R4 data read",
            int'(feed_data), int'(img_of(dcount)));
        mreq_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        dcount++;
    endtask

    task automatic mem_write(input int hold);
        @(negedge clk);
        mreq_n = 1'b0; wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        chk(ram_wr_en == 1'b1, "R7 write passes", int'(ram_wr_en), 1);
        chk(feed_oe == 1'b0, "R7 no drive on write", int'(feed_oe), 0);
        mreq_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic io_write();
        @(negedge clk);
        iorq_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        iorq_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(forced_mode == 1'b1, "R9 forced after reset", int'(forced_mode), 1);
        chk(feed_oe == 1'b0, "R9 idle no drive", int'(feed_oe), 0);
        chk(img_index == 8'd0, "R9 index zero", int'(img_index), 0);
        chk(ram_rd_en == 1'b0, "R6 ram blocked at reset", int'(ram_rd_en), 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R7: vector table for the script head and first two copies
        for (int v = 0; v < NVEC; v++) begin
            case (VEC[v][9:8])
                K_OP:    bus_read(1'b1, VEC[v][7:0], 1, "R1 fetch");
                K_OPR:   bus_read(1'b0, VEC[v][7:0], 1, "R3 operand");
                K_DAT:   data_read(1);
                default: mem_write(1);
            endcase
        end

        // R2 R5 R8: remaining copies, with stretched cycles and an early I/O write
        for (int i = 2; i < N; i++) begin
            bus_read(1'b1, 8'hED, (i == 40) ? 5 : 1, "R2 copy prefix");
            bus_read(1'b1, 8'hA0, 1, "R2 copy opcode");
            data_read((i == 5) ? 6 : 1);            // R5: long read steps once
            mem_write((i == 7) ? 4 : 1);
            if (i == 10) begin
                io_write();
                chk(forced_mode == 1'b1, "R8 early io ignored", int'(forced_mode), 1);
            end
        end

        // R2 R3: trailer, then a position past the end
        bus_read(1'b1, 8'h3E, 1, "R2 trailer load");
        bus_read(1'b0, CFG, 1, "R3 cfg operand");
        bus_read(1'b1, 8'hD3, 1, "R2 trailer out");
        bus_read(1'b0, PORT, 1, "R3 port operand");
        bus_read(1'b1, 8'h00, 1, "R2 past end");
        chk(img_index == 8'(N), "R10 index wrapped after full image", int'(img_index), 0);

        // R8: exit write
        io_write();
        chk(forced_mode == 1'b0, "R8 exit forced", int'(forced_mode), 0);
        chk(ram_rd_en == 1'b1, "R6 ram read restored", int'(ram_rd_en), 1);
        @(negedge clk);
        mreq_n = 1'b0; rd_n = 1'b0; m1_n = 1'b0;
        @(negedge clk);
        chk(feed_oe == 1'b0, "R6 no drive after exit", int'(feed_oe), 0);
        m1_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);

        // R9: reset after exit, then again in the middle of a run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(forced_mode == 1'b1, "R9 forced re-entered", int'(forced_mode), 1);
        bus_read(1'b1, 8'h11, 1, "R9 restart fetch");
        bus_read(1'b0, 8'h00, 1, "R9 restart operand");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(1'b1, 8'h11, 1, "R9 mid-run reset fetch");
        chk(img_index == 8'd0, "R9 index cleared", int'(img_index), 0);
        finish_run();
    end
endmodule